// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block bridges a clocked request interface to a byte-wide asynchronous static memory with 32K locations. A client presents one read or one write at a time with a valid/ready handshake. The controller then drives the memory's active-low chip select, write strobe and output strobe, a 15-bit address and a split data pad made of output value, output enable and input value. A read returns its byte together with a single-cycle done strobe. A write ends with the same strobe.

All memory timing minimums are parameters given in nanoseconds, along with the clock period. Each phase length is computed from them in whole clock cycles. A write is timed by its write-strobe-low window, since the memory stores data only while select and write strobe are both low. Data setup is therefore counted back from the rising write-strobe edge. A build option keeps the output strobe low during writes. In that mode the write pulse is stretched so that the memory releases the bus before the controller drives it. In the default mode the controller waits a turnaround interval after a read before it drives the bus.

Top module: `sram_bridge`

## Requirements
- R1: `req_ready` is high only when no transfer is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the transfer has finished.
- R2: A write holds `sram_we_n` low for exactly PULSE cycles. In the default mode PULSE is the largest of the cycle counts for the 50 ns write pulse, the 60 ns address-to-write-end time and the 30 ns data setup. `sram_we_n` is never low while `sram_ce_n` is high.
- R3: `sram_dq_oe` is high only while `sram_we_n` is low, and `sram_dq_o` does not change while it is driven. In the default mode the data is driven for every cycle of the write pulse, so setup is PULSE cycles before the rising write-strobe edge.
- R4: `sram_addr` stays stable for every cycle that `sram_ce_n` is low.
- R5: After the write strobe rises, `sram_ce_n` stays low for HOLD cycles, where HOLD = max(1, cycles(70 ns) - PULSE). `rsp_done` follows PULSE+HOLD+1 cycles after the accepting edge.
- R6: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for RD cycles, where RD is the largest of the cycle counts for 70 ns read cycle, 70 ns address access and 35 ns output-strobe access. `sram_dq_i` is sampled on the edge that ends the last such cycle. `rsp_rdata` carries that byte when `rsp_done` rises, RD+1 cycles after the accepting edge.
- R7: `rsp_done` is high for exactly one cycle per transfer, and `rsp_rdata` keeps the last read byte through later writes.
- R8: In the default mode, at least TA = cycles(25 ns) cycles with `sram_oe_n` high pass before `sram_dq_oe` rises. A write that follows a read immediately therefore takes TA-1 extra cycles.
- R9: With `OE_LOW_WR`=1, `sram_oe_n` stays low while `sram_we_n` is low. PULSE becomes the largest of the cycle counts for 50 ns, 60 ns and cycles(25 ns)+cycles(30 ns). The data is driven only in the last PULSE - cycles(25 ns) cycles of the pulse.
- R10: Every cycle count is ceil(ns / CLK_NS) with a floor of one cycle.
- R11: During and right after reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, `sram_dq_oe` and `rsp_done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle end-of-transfer strobe |
| rsp_rdata | output | DATA_W | Last byte read |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data pad output value |
| sram_dq_oe | output | 1 | Data pad output enable |
| sram_dq_i | input | DATA_W | Data pad input value |

## Verification
The bench builds two instances with a 6-bit address and a 20 ns clock. One uses the default output-strobe mode and the other holds the output strobe low during writes. The small address space allows every location to be written and read back. At this clock period the phase counts all differ: write pulse 3 versus 4, drive delay 2, turnaround 2, read 4, and a hold that falls back to its one-cycle floor. An off-by-one in any of them therefore changes a measured strobe width or a latency. The bench's memory model returns a poison byte until the read has lasted its full count, so a read that samples early is caught.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WTURN  = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4
  } phase_e;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
`timescale 1ns/1ps
// Down counter holding the number of cycles left in the current phase.
module sram_bridge_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/sram_bridge_dq.sv
`timescale 1ns/1ps
// Data pad stage: write byte register, drive enable and read capture.
module sram_bridge_dq #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_wdata,
  input  logic [DW-1:0] wdata,
  input  logic          drive_nx,
  input  logic          capture,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic          pad_oe,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_out <= '0;
      pad_oe  <= 1'b0;
      rdata   <= '0;
    end else begin
      if (load_wdata) pad_out <= wdata;
      pad_oe <= drive_nx;
      if (capture)    rdata <= pad_in;
    end
  end

endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_WP_NS   = 50,
  parameter int unsigned T_SD_NS   = 30,
  parameter int unsigned T_AW_NS   = 60,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_DOE_NS  = 35,
  parameter int unsigned T_HZOE_NS = 25,
  parameter int unsigned T_HZWE_NS = 25,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  // Phase lengths in clock cycles.
  localparam int unsigned WP_C   = ns_to_cyc(T_WP_NS,   CLK_NS);
  localparam int unsigned SD_C   = ns_to_cyc(T_SD_NS,   CLK_NS);
  localparam int unsigned AW_C   = ns_to_cyc(T_AW_NS,   CLK_NS);
  localparam int unsigned WC_C   = ns_to_cyc(T_WC_NS,   CLK_NS);
  localparam int unsigned RC_C   = ns_to_cyc(T_RC_NS,   CLK_NS);
  localparam int unsigned AA_C   = ns_to_cyc(T_AA_NS,   CLK_NS);
  localparam int unsigned DOE_C  = ns_to_cyc(T_DOE_NS,  CLK_NS);
  localparam int unsigned HZOE_C = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned HZWE_C = ns_to_cyc(T_HZWE_NS, CLK_NS);

  localparam int unsigned PULSE_C = OE_LOW_WR ? max2(max2(WP_C, AW_C), HZWE_C + SD_C)
                                              : max2(max2(WP_C, AW_C), SD_C);
  localparam int unsigned DLY_C   = OE_LOW_WR ? HZWE_C : 0;
  localparam int unsigned HOLD_C  = (WC_C > PULSE_C + 1) ? (WC_C - PULSE_C) : 1;
  localparam int unsigned RD_C    = max2(max2(AA_C, DOE_C), RC_C);
  localparam int unsigned TA_C    = HZOE_C;
  localparam int unsigned MAX_C   = max2(max2(PULSE_C, HOLD_C), max2(RD_C, TA_C));
  localparam int unsigned CW      = $clog2(MAX_C + 1);

  phase_e state_q, state_d;

  logic [CW-1:0] ph_cnt, ph_val, ph_cnt_nx, ta_cnt;
  logic          ph_load, ph_last, ta_load, ta_last, ta_clear;

  // Named internal events, also observed by the checker.
  logic accept, wr_end, rd_end, drive_nx;

  sram_bridge_timer #(.W(CW)) u_ph (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
    .cnt(ph_cnt), .last(ph_last)
  );

  sram_bridge_timer #(.W(CW)) u_ta (
    .clk(clk), .rst_n(rst_n), .load(ta_load), .load_val(CW'(TA_C)),
    .cnt(ta_cnt), .last(ta_last)
  );

  // Bus free for driving once at most one turnaround cycle is left.
  assign ta_clear = ta_last || (ta_cnt == '0);

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    ta_load = 1'b0;
    accept  = 1'b0;
    wr_end  = 1'b0;
    rd_end  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            if (!OE_LOW_WR && !ta_clear) begin
              state_d = ST_WTURN;
            end else begin
              state_d = ST_WPULSE;
              ph_load = 1'b1;
              ph_val  = CW'(PULSE_C);
            end
          end else begin
            state_d = ST_RACC;
            ph_load = 1'b1;
            ph_val  = CW'(RD_C);
          end
        end
      end
      ST_WTURN: begin
        if (ta_clear) begin
          state_d = ST_WPULSE;
          ph_load = 1'b1;
          ph_val  = CW'(PULSE_C);
        end
      end
      ST_WPULSE: begin
        if (ph_last) begin
          state_d = ST_WHOLD;
          ph_load = 1'b1;
          ph_val  = CW'(HOLD_C);
        end
      end
      ST_WHOLD: begin
        if (ph_last) begin
          state_d = ST_IDLE;
          wr_end  = 1'b1;
        end
      end
      ST_RACC: begin
        if (ph_last) begin
          state_d = ST_IDLE;
          rd_end  = 1'b1;
          ta_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Drive window: the tail of the write pulse after the release delay.
  assign ph_cnt_nx = ph_load ? ph_val : (ph_cnt - CW'(1));
  assign drive_nx  = (state_d == ST_WPULSE) && (ph_cnt_nx <= CW'(PULSE_C - DLY_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_addr <= '0;
      rsp_done  <= 1'b0;
    end else begin
      state_q   <= state_d;
      sram_ce_n <= (state_d == ST_IDLE);
      sram_we_n <= (state_d != ST_WPULSE);
      sram_oe_n <= !((state_d == ST_RACC) || (OE_LOW_WR && (state_d == ST_WPULSE)));
      if (accept) sram_addr <= req_addr;
      rsp_done  <= wr_end || rd_end;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  sram_bridge_dq #(.DW(DATA_W)) u_dq (
    .clk(clk), .rst_n(rst_n),
    .load_wdata(accept), .wdata(req_wdata),
    .drive_nx(drive_nx), .capture(rd_end),
    .pad_in(sram_dq_i), .pad_out(sram_dq_o), .pad_oe(sram_dq_oe),
    .rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
`timescale 1ns/1ps
module sram_bridge_chk #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe,
  input logic              accept
);

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  p_drive_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !sram_we_n);

  p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  p_no_oe_we_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && !sram_we_n) |-> (OE_LOW_WR != 1'b0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OE_LOW_WR(OE_LOW_WR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
  .sram_dq_oe(sram_dq_oe), .accept(accept)
);

// File: tb/sim_sram_model.sv
`timescale 1ns/1ps
// Behavioural memory plus pin-timing monitor for one controller instance.
module sim_sram_model #(
  parameter int AW     = 6,
  parameter int PULSE  = 3,
  parameter int DLY    = 0,
  parameter int HOLD   = 1,
  parameter int RD     = 4,
  parameter int TA     = 2,
  parameter bit OE_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_o,
  input  logic          dq_oe,
  output logic [7:0]    dq_i,
  output int            nchk,
  output int            nerr
);

  logic [7:0] mem [1<<AW];
  int c_chk = 0, c_err = 0;
  int we_cnt = 0, drv_cnt = 0, rd_cnt = 0, oeh_cnt = 1000, hold_cnt = 0;
  bit in_hold = 0, prev_we_low = 0, prev_rd = 0, oe_bad = 0;
  logic [7:0] wlat = 8'h00;

  assign nchk = c_chk;
  assign nerr = c_err;
  // Poison byte until the read strobe has been held for the full count.
  assign dq_i = (!ce_n && !oe_n && we_n && rd_cnt >= RD) ? mem[addr] : 8'hEE;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    c_chk++;
    if (!ok) begin
      c_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
      we_cnt = 0; drv_cnt = 0; rd_cnt = 0; oeh_cnt = 1000; hold_cnt = 0;
      in_hold = 0; prev_we_low = 0; prev_rd = 0; oe_bad = 0;
    end else begin
      if (in_hold) begin
        if (!ce_n) hold_cnt++;
        else begin
          chk(hold_cnt == HOLD, "R5 select hold cycles", hold_cnt, HOLD);
          in_hold = 0;
        end
      end
      if (dq_oe) begin
        if (we_n) chk(1'b0, "R3 data driven with write strobe high", 1, 0);
        if (drv_cnt == 0 && !OE_LOW)
          chk(oeh_cnt >= TA, "R8 output-strobe-high cycles before drive", oeh_cnt, TA);
      end
      if (!we_n) begin
        we_cnt++;
        if (dq_oe) begin drv_cnt++; wlat = dq_o; end
        if (OE_LOW && oe_n) oe_bad = 1;
      end else if (prev_we_low) begin
        chk(we_cnt == PULSE, "R2 R9 R10 write strobe low cycles", we_cnt, PULSE);
        chk(drv_cnt == PULSE - DLY, "R3 R9 data drive cycles", drv_cnt, PULSE - DLY);
        if (OE_LOW) chk(!oe_bad, "R9 output strobe low across pulse", int'(oe_bad), 0);
        mem[addr] = wlat;
        we_cnt = 0; drv_cnt = 0; oe_bad = 0;
        in_hold = 1; hold_cnt = 1;
      end
      if (!ce_n && !oe_n && we_n) rd_cnt++;
      else begin
        if (prev_rd) chk(rd_cnt == RD, "R6 read strobe cycles", rd_cnt, RD);
        rd_cnt = 0;
      end
      prev_rd     = !ce_n && !oe_n && we_n;
      oeh_cnt     = oe_n ? ((oeh_cnt < 1000) ? oeh_cnt + 1 : oeh_cnt) : 0;
      prev_we_low = !we_n;
    end
  end

endmodule

// File: tb/sim_sram_bridge.sv
`timescale 1ns/1ps
module sim_sram_bridge;

  localparam int CLK_NS = 20;
  localparam int AW     = 6;

  function automatic int cy(input int ns);
    return (ns <= 0) ? 1 : ((ns - 1) / CLK_NS + 1);
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_P0   = mx(mx(cy(50), cy(60)), cy(30));
  localparam int E_P1   = mx(mx(cy(50), cy(60)), cy(25) + cy(30));
  localparam int E_DLY1 = cy(25);
  localparam int E_WC   = cy(70);
  localparam int E_H0   = mx(1, E_WC - E_P0);
  localparam int E_H1   = mx(1, E_WC - E_P1);
  localparam int E_RD   = mx(mx(cy(70), cy(70)), cy(35));
  localparam int E_TA   = cy(25);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, sel = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;

  logic rdy0, rdy1, done0, done1;
  logic ce0, we0, oe0, doe0, ce1, we1, oe1, doe1;
  logic [AW-1:0] a0, a1;
  logic [7:0] rd0, rd1, dqo0, dqo1, dqi0, dqi1;
  int mchk0, merr0, mchk1, merr1;

  sram_bridge #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CLK_NS), .OE_LOW_WR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_ready(rdy0),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(done0), .rsp_rdata(rd0), .sram_ce_n(ce0), .sram_we_n(we0),
    .sram_oe_n(oe0), .sram_addr(a0), .sram_dq_o(dqo0), .sram_dq_oe(doe0),
    .sram_dq_i(dqi0)
  );

  sram_bridge #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CLK_NS), .OE_LOW_WR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_ready(rdy1),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(done1), .rsp_rdata(rd1), .sram_ce_n(ce1), .sram_we_n(we1),
    .sram_oe_n(oe1), .sram_addr(a1), .sram_dq_o(dqo1), .sram_dq_oe(doe1),
    .sram_dq_i(dqi1)
  );

  sim_sram_model #(.AW(AW), .PULSE(E_P0), .DLY(0), .HOLD(E_H0), .RD(E_RD),
                   .TA(E_TA), .OE_LOW(1'b0)) m0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce0), .we_n(we0), .oe_n(oe0), .addr(a0),
    .dq_o(dqo0), .dq_oe(doe0), .dq_i(dqi0), .nchk(mchk0), .nerr(merr0)
  );

  sim_sram_model #(.AW(AW), .PULSE(E_P1), .DLY(E_DLY1), .HOLD(E_H1), .RD(E_RD),
                   .TA(E_TA), .OE_LOW(1'b1)) m1 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce1), .we_n(we1), .oe_n(oe1), .addr(a1),
    .dq_o(dqo1), .dq_oe(doe1), .dq_i(dqi1), .nchk(mchk1), .nerr(merr1)
  );

  int  n_chk = 0, n_err = 0;
  bit  ended = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input bit s);
    return {2'b01, 6'(a)} ^ (s ? 8'h2A : 8'h00);
  endfunction

  // Called on a falling edge; returns on the falling edge where done is seen.
  task automatic xfer(input bit wr, input int a, input logic [7:0] d,
                      input int lat, input logic [7:0] exp_rd);
    int n;
    while (!(sel ? rdy1 : rdy0)) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    check(!(sel ? rdy1 : rdy0), "R1 ready low after accept", int'(sel ? rdy1 : rdy0), 0);
    check(!(sel ? done1 : done0), "R7 done lasts one cycle", int'(sel ? done1 : done0), 0);
    while (!(sel ? done1 : done0) && n < 200) begin @(negedge clk); n++; end
    check(n == lat, wr ? "R5 R10 write latency" : "R6 R10 read latency", n, lat);
    if (!wr)
      check((sel ? rd1 : rd0) == exp_rd, "R6 read data", int'(sel ? rd1 : rd0), int'(exp_rd));
  endtask

  task automatic reset_checks(input string tag);
    check(ce0 && we0 && oe0 && ce1 && we1 && oe1, {"R11 strobes high ", tag},
          int'({ce0, we0, oe0, ce1, we1, oe1}), 63);
    check(!doe0 && !doe1 && !done0 && !done1, {"R11 drive and done low ", tag},
          int'({doe0, doe1, done0, done1}), 0);
    check(rdy0 && rdy1, {"R11 ready high ", tag}, int'({rdy0, rdy1}), 3);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err + merr0 + merr1,
               n_chk + mchk0 + mchk1);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_checks("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("after reset");

    // Default mode: full write sweep, then full read sweep (R2 R3 R4 R5 R6).
    sel = 1'b0;
    for (int a = 0; a < (1<<AW); a++) xfer(1'b1, a, pat(a, 0), E_P0 + E_H0 + 1, 8'h00);
    for (int a = 0; a < (1<<AW); a++) xfer(1'b0, a, 8'h00, E_RD + 1, pat(a, 0));

    // Write right after read: turnaround wait adds TA-1 cycles (R8).
    for (int a = 0; a < 16; a++) begin
      xfer(1'b0, a, 8'h00, E_RD + 1, pat(a, 0));
      xfer(1'b1, a, pat(a, 1), E_P0 + E_H0 + 1 + (E_TA - 1), 8'h00);
      xfer(1'b0, a, 8'h00, E_RD + 1, pat(a, 1));
    end

    // Read data held through a later write (R7).
    xfer(1'b0, 40, 8'h00, E_RD + 1, pat(40, 0));
    xfer(1'b1, 41, pat(41, 1), E_P0 + E_H0 + 1 + (E_TA - 1), 8'h00);
    check(rd0 == pat(40, 0), "R7 read data held across write", int'(rd0), int'(pat(40, 0)));

    // Output strobe held low during writes: longer pulse, delayed drive (R9).
    sel = 1'b1;
    for (int a = 0; a < 32; a++) begin
      xfer(1'b1, a, pat(a, 1), E_P1 + E_H1 + 1, 8'h00);
      xfer(1'b0, a, 8'h00, E_RD + 1, pat(a, 1));
    end
    for (int a = 0; a < 32; a++) xfer(1'b0, a, 8'h00, E_RD + 1, pat(a, 1));

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule